// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block lets a host read and write registers inside a peripheral that is reached over three wires: an active-low select, a serial clock and a single data line shared by both directions. The host gives a start strobe with a direction flag, a register address and, for a write, a data word. The block then runs the whole exchange and reports the end with a one-cycle done pulse.

The serial frame begins with a marker bit of value 1. A direction bit follows, then the address and, for a write, the data word. On a read the block stops driving the data line after the address. It lets two clock cycles pass unsampled while the peripheral turns the line around, then shifts in the reply. The serial clock is the system clock divided by an even, run-time ratio. One clock pulse is issued before the select goes low. On a read the select is held low for one extra clock cycle after the reply, while on a write it rises as soon as the last bit ends.

The shared line is brought out as three signals: a driven value, an output enable and a received value. A pad cell outside the block joins them into one wire.

Top module: `s3_reg_master`

## Requirements
- R1: While no transfer runs (after reset and between transfers), `cs_n_o` is 1, `sclk_o` is 0, `sd_oe_o` is 0 and `busy_o` is 0.
- R2: Each transfer begins with exactly one rising edge of `sclk_o` while `cs_n_o` is still 1. `cs_n_o` falls on the falling clock edge that ends this lead cycle.
- R3: Once `cs_n_o` has fallen it stays at 0 without a break until the transfer ends, so it has exactly one fall and one rise per transfer.
- R4: The master changes `sd_o` on falling `sclk_o` edges, holding `sd_oe_o` at 1, so that each bit is stable at the next rising edge. The bit order is: a marker bit of 1; a direction bit (0 = write, 1 = read); the ADDR_W address bits, MSB first; and for a write only, the DATA_W data bits, MSB first.
- R5: On a read, `sd_oe_o` drops on the falling edge after the last address bit. Data sampled on the next two rising edges is ignored. The following DATA_W rising edges capture `sd_i`, MSB first, and `sd_oe_o` stays 0 through all of them.
- R6: A write has 2+ADDR_W+DATA_W clock cycles with `cs_n_o` low, and `cs_n_o` rises on the falling edge that ends the last data bit. A read has 2+ADDR_W+2+DATA_W+1 such cycles: `cs_n_o` is held low for one extra clock cycle after the last sampled bit.
- R7: Each high phase and each low phase of `sclk_o` lasts `div_i` system clock cycles, with 0 treated as 1. The value is taken when the transfer starts.
- R8: A start strobe is taken only when `busy_o` is 0. A strobe given during a transfer has no effect on that transfer's frame, timing or result. All inputs are captured at the accepted strobe.
- R9: `done_o` is high for exactly one cycle at the end of every transfer, in the same cycle that `busy_o` is first 0. On a read, `rdata_o` then holds the captured word. A write leaves `rdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one transfer |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| div_i | input | DIV_W | Half-period of the serial clock in system clock cycles (0 acts as 1) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rdata_o | output | DATA_W | Last word read |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low select |
| sd_o | output | 1 | Value driven onto the data line |
| sd_oe_o | output | 1 | Drive enable for the data line |
| sd_i | input | 1 | Value received from the data line |

## Verification
The assertions take for granted that the host does not change `div_i` in a way that matters mid-transfer; this holds because the divider is latched when the transfer starts. They also take for granted that the peripheral drives `sd_i` only while `sd_oe_o` is low. The bench's peripheral model follows that rule. It drives the reply only in the data window, changes it on falling clock edges, and places random values on `sd_i` during the turnaround gap and between transfers, so any sampling in the gap shows up as a wrong word. Strobes are pulsed mid-transfer with altered inputs to exercise the acceptance rule.

// File: rtl/s3_pkg.sv
package s3_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SEND,
        ST_GAP,
        ST_RECV,
        ST_TAIL
    } s3_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    localparam int unsigned TURN_CYCLES = 2;

    function automatic int unsigned hdr_bits(int unsigned aw);
        return 2 + aw;
    endfunction

    function automatic int unsigned frame_bits(int unsigned aw, int unsigned dw);
        return 2 + aw + dw;
    endfunction

endpackage

// File: rtl/s3_sck_gen.sv
module s3_sck_gen
    import s3_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output sck_evt_t         evt_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             sclk_q;
    logic             tick;

    always_comb begin
        lim = (div_i == '0) ? '0 : div_i - 1'b1;
    end

    assign tick = run_i && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        evt_o.rise = tick & ~sclk_q;
        evt_o.fall = tick & sclk_q;
    end

    assign sclk_o = sclk_q;

    // R1: clock parks low once the transfer stops
    a_r1_sclk_parks_low: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !sclk_o);

    // R7: the phase counter never passes its limit
    a_r7_phase_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= lim));

endmodule

// File: rtl/s3_tx_shift.sv
module s3_tx_shift #(
    parameter int unsigned W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] data_i,
    output logic         msb_o
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= data_i;
        end else if (shift_i) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign msb_o = sr_q[W-1];

    // R4: a load and a shift never coincide
    a_r4_load_shift_excl: assert property (@(posedge clk) disable iff (rst)
        !(load_i && shift_i));

endmodule

// File: rtl/s3_rx_shift.sv
module s3_rx_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         bit_i,
    input  logic         commit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] sr_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            hold_q <= '0;
        end else begin
            if (en_i) begin
                sr_q <= {sr_q[W-2:0], bit_i};
            end
            if (commit_i) begin
                hold_q <= sr_q;
            end
        end
    end

    assign data_o = hold_q;

    // R9: result register changes only on a commit
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(data_o));

endmodule

// File: rtl/s3_ctrl.sv
module s3_ctrl
    import s3_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic [DIV_W-1:0] div_i,
    input  sck_evt_t         evt_i,
    output logic             run_o,
    output logic [DIV_W-1:0] div_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             cs_n_o,
    output logic             oe_o,
    output logic             tx_load_o,
    output logic             tx_shift_o,
    output logic             rx_en_o,
    output logic             rx_commit_o
);

    localparam int unsigned HB = hdr_bits(ADDR_W);
    localparam int unsigned FB = frame_bits(ADDR_W, DATA_W);
    localparam int unsigned CW = $clog2(FB + 1);

    s3_state_e        state_q;
    logic [CW-1:0]    cnt_q;
    logic             rd_q;
    logic [DIV_W-1:0] div_q;
    logic             cs_n_q;
    logic             oe_q;
    logic             done_q;
    logic             last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            div_q   <= '0;
            cs_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LEAD;
                        rd_q    <= rd_i;
                        div_q   <= div_i;
                    end
                end
                ST_LEAD: begin
                    if (evt_i.fall) begin
                        state_q <= ST_SEND;
                        cs_n_q  <= 1'b0;
                        oe_q    <= 1'b1;
                        cnt_q   <= rd_q ? CW'(HB - 1) : CW'(FB - 1);
                    end
                end
                ST_SEND: begin
                    if (evt_i.fall) begin
                        if (last) begin
                            oe_q <= 1'b0;
                            if (rd_q) begin
                                state_q <= ST_GAP;
                                cnt_q   <= CW'(TURN_CYCLES - 1);
                            end else begin
                                state_q <= ST_IDLE;
                                cs_n_q  <= 1'b1;
                                done_q  <= 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (evt_i.fall) begin
                        if (last) begin
                            state_q <= ST_RECV;
                            cnt_q   <= CW'(DATA_W - 1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (evt_i.fall) begin
                        if (last) begin
                            state_q <= ST_TAIL;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (evt_i.fall) begin
                        state_q <= ST_IDLE;
                        cs_n_q  <= 1'b1;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run_o       = (state_q != ST_IDLE);
    assign busy_o      = (state_q != ST_IDLE);
    assign div_o       = div_q;
    assign done_o      = done_q;
    assign cs_n_o      = cs_n_q;
    assign oe_o        = oe_q;
    assign tx_load_o   = (state_q == ST_IDLE) && start_i;
    assign tx_shift_o  = (state_q == ST_SEND) && evt_i.fall && !last;
    assign rx_en_o     = (state_q == ST_RECV) && evt_i.rise;
    assign rx_commit_o = (state_q == ST_TAIL) && evt_i.fall;

    // R1: idle lines are quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (cs_n_q && !oe_q));

    // R2: select still high during the lead cycle
    a_r2_lead_cs_high: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD) |-> cs_n_q);

    // R3: select rises only when the transfer ends
    a_r3_cs_rise_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_q) |-> (done_q && state_q == ST_IDLE));

    // R4: the line is driven only while selected
    a_r4_drive_selected: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> !cs_n_q);

    // R5: no drive during turnaround, reception or tail
    a_r5_listen_no_drive: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP || state_q == ST_RECV || state_q == ST_TAIL) |-> !oe_q);

    // R6: tail cycle only follows reception
    a_r6_tail_after_recv: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL) |-> ($past(state_q) == ST_RECV || $past(state_q) == ST_TAIL));

    // R8: a strobe while busy leaves the latched request alone
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> ($stable(rd_q) && $stable(div_q)));

    // R9: done lasts one cycle and coincides with idle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_o);

endmodule

// File: rtl/s3_reg_master.sv
module s3_reg_master
    import s3_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              sd_o,
    output logic              sd_oe_o,
    input  logic              sd_i
);

    localparam int unsigned FB = frame_bits(ADDR_W, DATA_W);

    sck_evt_t         evt;
    logic             run;
    logic [DIV_W-1:0] div_q;
    logic             tx_load;
    logic             tx_shift;
    logic             rx_en;
    logic             rx_commit;
    logic [FB-1:0]    frame;

    always_comb begin
        frame = {1'b1, rd_i, addr_i, (rd_i ? {DATA_W{1'b0}} : wdata_i)};
    end

    s3_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rd_i        (rd_i),
        .div_i       (div_i),
        .evt_i       (evt),
        .run_o       (run),
        .div_o       (div_q),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .cs_n_o      (cs_n_o),
        .oe_o        (sd_oe_o),
        .tx_load_o   (tx_load),
        .tx_shift_o  (tx_shift),
        .rx_en_o     (rx_en),
        .rx_commit_o (rx_commit)
    );

    s3_sck_gen #(
        .DIV_W (DIV_W)
    ) sck_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .div_i  (div_q),
        .sclk_o (sclk_o),
        .evt_o  (evt)
    );

    s3_tx_shift #(
        .W (FB)
    ) tx_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tx_load),
        .shift_i (tx_shift),
        .data_i  (frame),
        .msb_o   (sd_o)
    );

    s3_rx_shift #(
        .W (DATA_W)
    ) rx_i (
        .clk      (clk),
        .rst      (rst),
        .en_i     (rx_en),
        .bit_i    (sd_i),
        .commit_i (rx_commit),
        .data_o   (rdata_o)
    );

endmodule

// File: tb/s3_reg_master_tb.sv
module s3_reg_master_tb_top;

    localparam int AW = 7;
    localparam int DW = 16;
    localparam int VW = 4;
    localparam int HB = 2 + AW;
    localparam int FB = 2 + AW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          rd_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [VW-1:0] div_i = '0;
    logic          busy_o, done_o, sclk_o, cs_n_o, sd_o, sd_oe_o;
    logic [DW-1:0] rdata_o;
    logic          sd_i = 1'b0;

    always #2 clk = ~clk;

    s3_reg_master #(.ADDR_W(AW), .DATA_W(DW), .DIV_W(VW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .div_i(div_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .sd_o(sd_o),
        .sd_oe_o(sd_oe_o), .sd_i(sd_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // peripheral model and edge monitor state
    logic [63:0]   cap;
    int            rc, lead_rises, cs_rises, cs_falls, done_cnt, per_err, oe_err, run_len;
    bit            have_prev;
    logic          sclk_prev = 1'b0;
    logic          cs_prev = 1'b1;
    bit            x_rd;
    logic [DW-1:0] x_rdat;
    int            x_eff;
    int            x_nsend;
    logic [DW-1:0] last_rdata = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(bit rd, logic [AW-1:0] a, logic [DW-1:0] w);
        if (rd) return 64'({2'b11, a});
        return 64'({2'b10, a, w});
    endfunction

    function automatic int exp_cycles(bit rd);
        return rd ? (HB + 2 + DW + 1) : FB;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            run_len++;
            if (sclk_o != sclk_prev) begin
                if (have_prev && run_len != x_eff) per_err++;
                have_prev = 1'b1;
                run_len = 0;
            end
            if (sclk_o && !sclk_prev) begin
                if (cs_n_o) begin
                    lead_rises++;
                end else begin
                    rc++;
                    if (rc <= x_nsend) begin
                        if (!sd_oe_o) oe_err++;
                        cap = {cap[62:0], sd_o};
                    end else if (sd_oe_o) begin
                        oe_err++;
                    end
                end
            end
            if (!sclk_o && sclk_prev && !cs_n_o) begin
                int nxt;
                nxt = rc + 1;
                if (x_rd && nxt >= 5 + AW && nxt <= 4 + AW + DW)
                    sd_i = x_rdat[DW - 1 - (nxt - (5 + AW))];
                else
                    sd_i = 1'($urandom);
            end
            if (cs_n_o && !cs_prev) cs_rises++;
            if (!cs_n_o && cs_prev) cs_falls++;
            if (done_o) begin
                done_cnt++;
                have_prev = 1'b0;
            end
            sclk_prev = sclk_o;
            cs_prev   = cs_n_o;
        end
    end

    task automatic run_xfer(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] w,
                            input logic [DW-1:0] rdat, input logic [VW-1:0] dv, input bit poke);
        int t;
        @(negedge clk);
        cap = '0; rc = 0; lead_rises = 0; cs_rises = 0; cs_falls = 0;
        done_cnt = 0; per_err = 0; oe_err = 0; run_len = 0; have_prev = 1'b0;
        x_rd = rd; x_rdat = rdat; x_eff = (dv == 0) ? 1 : int'(dv);
        x_nsend = rd ? HB : FB;
        start_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = w; div_i = dv;
        @(negedge clk);
        start_i = 1'b0;
        rd_i = ~rd; addr_i = ~a; wdata_i = ~w; div_i = VW'($urandom);
        if (poke) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!done_o && t < 20000);
        chk(done_o, "R9 done seen", 64'(done_o), 64'd1);
        chk(!busy_o, "R9 busy low with done", 64'(busy_o), 64'd0);
        if (rd) begin
            chk(rdata_o == rdat, "R5 read word", 64'(rdata_o), 64'(rdat));
            last_rdata = rdat;
        end else begin
            chk(rdata_o == last_rdata, "R9 write keeps rdata", 64'(rdata_o), 64'(last_rdata));
        end
        repeat (3) @(negedge clk);
        chk(cap == exp_frame(rd, a, w), poke ? "R8 frame under busy strobe" : "R4 frame bits",
            cap, exp_frame(rd, a, w));
        chk(lead_rises == 1, "R2 lead clock", 64'(lead_rises), 64'd1);
        chk(cs_falls == 1 && cs_rises == 1, "R3 select unbroken",
            64'({cs_falls[15:0], cs_rises[15:0]}), 64'h0001_0001);
        chk(rc == exp_cycles(rd), "R6 selected cycles", 64'(rc), 64'(exp_cycles(rd)));
        chk(oe_err == 0, "R5 drive enable window", 64'(oe_err), 64'd0);
        chk(per_err == 0, "R7 half period", 64'(per_err), 64'd0);
        chk(done_cnt == 1, "R9 done width", 64'(done_cnt), 64'd1);
        chk(cs_n_o && !sclk_o && !sd_oe_o && !busy_o, "R1 idle lines",
            64'({cs_n_o, sclk_o, sd_oe_o, busy_o}), 64'b1000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n_o && !sclk_o && !sd_oe_o && !busy_o && !done_o && rdata_o == '0,
            "R1 reset state", 64'({cs_n_o, sclk_o, sd_oe_o, busy_o, done_o, rdata_o}),
            64'({1'b1, 4'b0, 16'h0}));
        // directed corners
        run_xfer(1'b1, 7'h7f, 16'h0000, 16'hffff, 4'd0, 1'b0);
        run_xfer(1'b0, 7'h00, 16'ha5c3, 16'h0000, 4'd3, 1'b0);
        run_xfer(1'b1, 7'h55, 16'h1234, 16'h8001, 4'd1, 1'b1);
        run_xfer(1'b0, 7'h2a, 16'hffff, 16'h0f0f, 4'd2, 1'b1);
        run_xfer(1'b1, 7'h01, 16'h0000, 16'h0000, 4'd5, 1'b0);
        // constrained random
        for (int i = 0; i < 30; i++) begin
            run_xfer(1'($urandom), AW'($urandom), DW'($urandom), DW'($urandom),
                     VW'($urandom % 4), (i % 5) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule